// File: doc/BRIEF.md
# Lifting-Weight Lookup Table with Start-up Loader and SECDED Protection

This block holds the table that turns the training result of one pairwise decorrelation step into the settings of its lifting network. A lookup presents two training parameters, a flip bit and a flag that selects balanced or unbalanced operation. It returns three lifting weights, a flag that negates the outputs and a flag that exchanges them. The table lives in on-chip RAM and not in gates, because the gate count of a hard-wired table climbs steeply as the weight precision grows.

After reset a loader copies the table, one word per entry, from an external non-volatile memory through a plain read-request / read-valid interface. Each word is protected by an extended Hamming code as it is written. The block raises `ready` only once the last entry is in RAM. A lookup that is held while `ready` is low is stalled and is served once the table is complete. Every lookup result comes with two flags: one says a single-bit error was corrected, the other says an uncorrectable double-bit error was found.

Top module: `wt_ecc_table`

## Requirements
- R1: After reset the loader issues exactly one read per table entry, at addresses 0, 1, 2, ... in ascending order. `nvm_rd` is a one-cycle pulse, and the next pulse comes only after `nvm_rvalid` has returned the previous word.
- R2: `ready` is low from reset until the word for the last address (2^(2*PAR_W+2)-1) has been written. It then rises and stays high, and no further `nvm_rd` pulses occur.
- R3: The entry index of a lookup is {lk_unbal, lk_flip, lk_ta, lk_tb}, with lk_tb in the least significant bits. It equals the external memory address the entry was loaded from.
- R4: A lookup is accepted only on a rising edge where `lk_req` and `ready` are both high. While `ready` is low no result is produced, and a request held across the end of loading is served once.
- R5: Results appear exactly two cycles after acceptance (`lk_valid` high for one cycle per accepted request), and a new request may be accepted every cycle.
- R6: Stored word layout, which the result fields follow: bit 0 = swap flag, bit 1 = negate flag, bits [2+WGT_W-1:2] = weight 0, the next WGT_W bits = weight 1, the top WGT_W bits = weight 2.
- R7: If any one bit of a stored codeword (the data, Hamming check and overall parity bits included) is inverted, the lookup returns the original fields with `lk_corr`=1 and `lk_unc`=0.
- R8: If two distinct bits of a stored codeword are inverted, the lookup reports `lk_unc`=1 and `lk_corr`=0.
- R9: For an unaltered entry both `lk_corr` and `lk_unc` are 0. Both flags are 0 whenever `lk_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nvm_rd | output | 1 | One-cycle read request to external memory |
| nvm_addr | output | 2*PAR_W+2 | External memory word address |
| nvm_rvalid | input | 1 | Read data valid |
| nvm_rdata | input | 3*WGT_W+2 | Raw table word |
| ready | output | 1 | Table fully loaded |
| lk_req | input | 1 | Lookup request |
| lk_ta | input | PAR_W | First training parameter |
| lk_tb | input | PAR_W | Second training parameter |
| lk_flip | input | 1 | Flip input |
| lk_unbal | input | 1 | 1 = unbalanced operation |
| lk_valid | output | 1 | Result valid |
| lk_w0 | output | WGT_W | Lifting weight 0 |
| lk_w1 | output | WGT_W | Lifting weight 1 |
| lk_w2 | output | WGT_W | Lifting weight 2 |
| lk_neg | output | 1 | Negate-outputs flag |
| lk_swap | output | 1 | Exchange-outputs flag |
| lk_corr | output | 1 | Single-bit error corrected |
| lk_unc | output | 1 | Uncorrectable error detected |

## Verification
A lookup driven before the rising edge that accepts it has its result on the second rising edge after that one. The bench therefore drives requests on falling edges and compares each result two falling edges later, with a new index every cycle, so that one pass covers all 256 entries back to back. The loader's address is compared on the falling edge of each read pulse. The stored word is written on the edge that samples `nvm_rvalid`, and the responder varies its delay from one to three cycles. For the held request at the end of loading, `ready` is seen on one falling edge, the result must still be absent on the next and must appear on the one after.

// File: rtl/wt_pkg.sv
package wt_pkg;

  // Number of Hamming check bits needed to cover dw data bits.
  function automatic int secded_check_bits(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v & (v - 1)) == 0;
  endfunction

  typedef enum logic [1:0] {LD_IDLE, LD_REQ, LD_WAIT, LD_DONE} ld_state_t;

endpackage

// File: rtl/wt_secded_enc.sv
module wt_secded_enc #(
  parameter int DATA_W = 26
) (
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W+wt_pkg::secded_check_bits(DATA_W):0] code
);
  import wt_pkg::*;
  localparam int R    = secded_check_bits(DATA_W);
  localparam int HW   = DATA_W + R;
  localparam int CW_W = HW + 1;

  function automatic logic [CW_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [CW_W-1:0] c;
    logic par;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p <= HW; p++) begin
      if (!is_pow2(p)) begin
        c[p] = d[k];
        k++;
      end
    end
    for (int i = 0; i < R; i++) begin
      par = 1'b0;
      for (int p = 1; p <= HW; p++)
        if ((p & (1 << i)) != 0) par ^= c[p];
      c[1 << i] = par;
    end
    c[0] = ^c[CW_W-1:1];
    return c;
  endfunction

  assign code = encode(data);
endmodule

// File: rtl/wt_secded_dec.sv
module wt_secded_dec #(
  parameter int DATA_W = 26
) (
  input  logic [DATA_W+wt_pkg::secded_check_bits(DATA_W):0] code,
  output logic [DATA_W-1:0] data,
  output logic              corr,
  output logic              unc
);
  import wt_pkg::*;
  localparam int R    = secded_check_bits(DATA_W);
  localparam int HW   = DATA_W + R;
  localparam int CW_W = HW + 1;

  logic [R-1:0]    syn;
  logic            ovp;
  logic [CW_W-1:0] fixed;

  always_comb begin
    int k;
    syn = '0;
    for (int p = 1; p <= HW; p++)
      if (code[p]) syn ^= R'(p);
    ovp   = ^code;
    fixed = code;
    corr  = 1'b0;
    unc   = 1'b0;
    if (ovp) begin
      if (int'(syn) <= HW) begin
        fixed[syn] = ~fixed[syn];   // syn==0 repairs the overall parity bit
        corr       = 1'b1;
      end else begin
        unc = 1'b1;
      end
    end else if (syn != '0) begin
      unc = 1'b1;
    end
    data = '0;
    k    = 0;
    for (int p = 1; p <= HW; p++) begin
      if (!is_pow2(p)) begin
        data[k] = fixed[p];
        k++;
      end
    end
  end
endmodule

// File: rtl/wt_store.sv
module wt_store #(
  parameter int AW = 8,
  parameter int W  = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic          re,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[wa] <= wd;
    if (re) rd <= cells[ra];
  end
endmodule

// File: rtl/wt_loader.sv
module wt_loader #(
  parameter int AW     = 8,
  parameter int DATA_W = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              nvm_rd,
  output logic [AW-1:0]     nvm_addr,
  input  logic              nvm_rvalid,
  input  logic [DATA_W-1:0] nvm_rdata,
  output logic              wr_en,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              ready
);
  import wt_pkg::*;
  localparam logic [AW-1:0] LAST = '1;

  ld_state_t     st;
  logic [AW-1:0] addr;
  logic          at_last;

  assign at_last = (addr == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= LD_IDLE;
      addr <= '0;
    end else begin
      unique case (st)
        LD_IDLE: st <= LD_REQ;
        LD_REQ:  st <= LD_WAIT;
        LD_WAIT: if (nvm_rvalid) begin
          if (at_last) st <= LD_DONE;
          else begin
            addr <= addr + 1'b1;
            st   <= LD_REQ;
          end
        end
        default: st <= LD_DONE;
      endcase
    end
  end

  assign nvm_rd   = (st == LD_REQ);
  assign nvm_addr = addr;
  assign wr_en    = (st == LD_WAIT) && nvm_rvalid;
  assign wr_addr  = addr;
  assign wr_data  = nvm_rdata;
  assign ready    = (st == LD_DONE);

  // R2
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  // R2
  no_read_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !nvm_rd);
  // R1
  read_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_rd |=> !nvm_rd);
  // R1
  addr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nvm_rd |=> $stable(nvm_addr));
endmodule

// File: rtl/wt_ecc_table.sv
module wt_ecc_table #(
  parameter int PAR_W = 3,
  parameter int WGT_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic                   nvm_rd,
  output logic [2*PAR_W+1:0]     nvm_addr,
  input  logic                   nvm_rvalid,
  input  logic [3*WGT_W+1:0]     nvm_rdata,
  output logic                   ready,
  input  logic                   lk_req,
  input  logic [PAR_W-1:0]       lk_ta,
  input  logic [PAR_W-1:0]       lk_tb,
  input  logic                   lk_flip,
  input  logic                   lk_unbal,
  output logic                   lk_valid,
  output logic [WGT_W-1:0]       lk_w0,
  output logic [WGT_W-1:0]       lk_w1,
  output logic [WGT_W-1:0]       lk_w2,
  output logic                   lk_neg,
  output logic                   lk_swap,
  output logic                   lk_corr,
  output logic                   lk_unc
);
  import wt_pkg::*;
  localparam int AW     = 2 * PAR_W + 2;
  localparam int DATA_W = 3 * WGT_W + 2;
  localparam int CW_W   = DATA_W + secded_check_bits(DATA_W) + 1;

  logic              wr_en;
  logic [AW-1:0]     wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [CW_W-1:0]   wr_code;
  logic [CW_W-1:0]   rd_code;
  logic [DATA_W-1:0] dec_data;
  logic              dec_corr, dec_unc;
  logic              accept;
  logic [AW-1:0]     lk_addr;
  logic              s1_vld;

  assign accept  = lk_req && ready;
  assign lk_addr = {lk_unbal, lk_flip, lk_ta, lk_tb};

  wt_loader #(.AW(AW), .DATA_W(DATA_W)) u_loader (
    .clk(clk), .rst_n(rst_n),
    .nvm_rd(nvm_rd), .nvm_addr(nvm_addr),
    .nvm_rvalid(nvm_rvalid), .nvm_rdata(nvm_rdata),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ready(ready)
  );

  wt_secded_enc #(.DATA_W(DATA_W)) u_enc (.data(wr_data), .code(wr_code));

  wt_store #(.AW(AW), .W(CW_W)) u_store (
    .clk(clk), .we(wr_en), .wa(wr_addr), .wd(wr_code),
    .re(accept), .ra(lk_addr), .rd(rd_code)
  );

  wt_secded_dec #(.DATA_W(DATA_W)) u_dec (
    .code(rd_code), .data(dec_data), .corr(dec_corr), .unc(dec_unc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_vld   <= 1'b0;
      lk_valid <= 1'b0;
      lk_corr  <= 1'b0;
      lk_unc   <= 1'b0;
      lk_w0    <= '0;
      lk_w1    <= '0;
      lk_w2    <= '0;
      lk_neg   <= 1'b0;
      lk_swap  <= 1'b0;
    end else begin
      s1_vld   <= accept;
      lk_valid <= s1_vld;
      lk_corr  <= s1_vld && dec_corr;
      lk_unc   <= s1_vld && dec_unc;
      if (s1_vld) begin
        lk_swap <= dec_data[0];
        lk_neg  <= dec_data[1];
        lk_w0   <= dec_data[2 +: WGT_W];
        lk_w1   <= dec_data[2 + WGT_W +: WGT_W];
        lk_w2   <= dec_data[2 + 2*WGT_W +: WGT_W];
      end
    end
  end

  // R5
  lat_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ##2 lk_valid);
  // R4
  no_early_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $past(ready, 2));
  // R7
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $onehot0({lk_corr, lk_unc}));
  // R9
  flags_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_corr || lk_unc));
endmodule

// File: tb/sim_wt_ecc_table.sv
module sim_wt_ecc_table;
  localparam int PAR_W  = 3;
  localparam int WGT_W  = 8;
  localparam int AW     = 2 * PAR_W + 2;
  localparam int DEPTH  = 1 << AW;
  localparam int DATA_W = 3 * WGT_W + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nvm_rd, nvm_rvalid, ready;
  logic [AW-1:0] nvm_addr;
  logic [DATA_W-1:0] nvm_rdata;
  logic lk_req, lk_flip, lk_unbal;
  logic [PAR_W-1:0] lk_ta, lk_tb;
  logic lk_valid, lk_neg, lk_swap, lk_corr, lk_unc;
  logic [WGT_W-1:0] lk_w0, lk_w1, lk_w2;

  int n_chk = 0, n_fail = 0, n_reads = 0, exp_rd = 0, cyc = 0;
  bit done = 0;

  always #2 clk = ~clk;   // 250 MHz

  wt_ecc_table #(.PAR_W(PAR_W), .WGT_W(WGT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .nvm_rd(nvm_rd), .nvm_addr(nvm_addr),
    .nvm_rvalid(nvm_rvalid), .nvm_rdata(nvm_rdata), .ready(ready),
    .lk_req(lk_req), .lk_ta(lk_ta), .lk_tb(lk_tb), .lk_flip(lk_flip),
    .lk_unbal(lk_unbal), .lk_valid(lk_valid), .lk_w0(lk_w0), .lk_w1(lk_w1),
    .lk_w2(lk_w2), .lk_neg(lk_neg), .lk_swap(lk_swap), .lk_corr(lk_corr),
    .lk_unc(lk_unc)
  );

  // Table word for an address, built arithmetically.
  function automatic logic [DATA_W-1:0] nvm_word(input int a);
    int v;
    v = (a * 37 + 11) ^ (a << 13) ^ (a << 19) ^ (a * 5 << 7);
    return v[DATA_W-1:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  // R1: address order of loader reads
  always @(negedge clk) begin
    if (rst_n && nvm_rd) begin
      chk(nvm_addr == AW'(exp_rd), "R1 read address order", nvm_addr, exp_rd);
      exp_rd++;
      n_reads++;
    end
  end

  // External memory model with 1..3 cycle response delay
  initial begin
    nvm_rvalid = 1'b0;
    nvm_rdata  = '0;
    forever begin
      if (rst_n && nvm_rd) begin
        int a;
        a = int'(nvm_addr);
        repeat (1 + a % 3) @(negedge clk);
        nvm_rvalid = 1'b1;
        nvm_rdata  = nvm_word(a);
        @(negedge clk);
        nvm_rvalid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 100000);
      finish_run();
    end
  end

  task automatic set_index(input int i);
    logic [AW-1:0] v;
    v = AW'(i);
    {lk_unbal, lk_flip, lk_ta, lk_tb} = v;   // R3 index formation
  endtask

  // mode 0: clean table; mode 1: injected errors
  task automatic check_out(input int k, input int mode);
    logic [DATA_W-1:0] d;
    bit single, dbl;
    d = nvm_word(k);
    single = (mode == 1) && (k < 32);
    dbl    = (mode == 1) && (k >= 32) && (k < 48);
    chk(lk_valid == 1'b1, "R5 valid two cycles after accept", lk_valid, 1);
    if (dbl) begin
      chk(lk_unc == 1'b1 && lk_corr == 1'b0, "R8 double error flagged",
          {lk_corr, lk_unc}, 2'b01);
    end else begin
      chk({lk_w2, lk_w1, lk_w0, lk_neg, lk_swap} == d,
          single ? "R7 corrected fields" : "R3 R6 fields at index",
          {lk_w2, lk_w1, lk_w0, lk_neg, lk_swap}, d);
      if (single)
        chk(lk_corr == 1'b1 && lk_unc == 1'b0, "R7 corrected flag",
            {lk_corr, lk_unc}, 2'b10);
      else
        chk(lk_corr == 1'b0 && lk_unc == 1'b0, "R9 clean flags",
            {lk_corr, lk_unc}, 2'b00);
    end
  endtask

  task automatic sweep(input int mode);
    for (int i = 0; i < DEPTH + 2; i++) begin
      if (i >= 2) check_out(i - 2, mode);
      if (i < DEPTH) begin
        lk_req = 1'b1;
        set_index(i);
      end else begin
        lk_req = 1'b0;
      end
      @(negedge clk);
    end
    chk(lk_valid == 1'b0 && lk_corr == 1'b0 && lk_unc == 1'b0,
        "R9 R5 idle after sweep", {lk_valid, lk_corr, lk_unc}, 0);
  endtask

  initial begin
    int early;
    lk_req = 1'b0;
    set_index(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(ready == 1'b0, "R2 ready low after reset", ready, 0);
    chk(lk_valid == 1'b0, "R4 no result after reset", lk_valid, 0);

    // R4: hold a request across the whole load
    lk_req = 1'b1;
    set_index(77);
    early = 0;
    while (!ready) begin
      @(negedge clk);
      if (lk_valid) early++;
    end
    chk(early == 0, "R4 no result while loading", early, 0);
    chk(n_reads == DEPTH, "R2 ready after last entry", n_reads, DEPTH);
    @(negedge clk);
    lk_req = 1'b0;
    chk(lk_valid == 1'b0, "R5 not yet after one cycle", lk_valid, 0);
    @(negedge clk);
    check_out(77, 0);
    @(negedge clk);
    chk(lk_valid == 1'b0, "R4 held request served once", lk_valid, 0);

    // R1 R2: no more reads, ready stays high
    repeat (10) @(negedge clk);
    chk(n_reads == DEPTH, "R2 no reads after ready", n_reads, DEPTH);
    chk(ready == 1'b1, "R2 ready sticky", ready, 1);

    // Full clean sweep, back to back
    sweep(0);

    // Inject errors into the stored codewords
    for (int k = 0; k < 32; k++)
      u0.u_store.cells[k] = u0.u_store.cells[k] ^ (32'h1 << k);
    for (int k = 32; k < 48; k++)
      u0.u_store.cells[k] = u0.u_store.cells[k] ^ (32'h1 << (k - 32))
                                                ^ (32'h1 << ((k - 25) % 32));
    sweep(1);

    done = 1;
    finish_run();
  end
endmodule